// File: doc/BRIEF.md
# Register Alias Table with Architectural Register File

This block keeps, for every architectural register, the name of the reservation station that will deliver that register's newest value. A zero name means the architectural register file already holds the current value. It sits between in-order dispatch and the result bus of a scheduler that copies operand values into its reservation stations. On a dispatch cycle it answers each source operand with either a ready value or a pending station tag, and it records the allocated station as the new producer of the destination register.

When a result is broadcast as a tag/value pair, the table searches all of its entries for that tag. The register whose entry still names the broadcasting station takes the value into the register file, and its entry returns to zero. If a younger dispatch has already renamed the register, no entry matches. The result then updates nothing here, because the consumers that need it already hold their own copies. Dispatch therefore never stalls on a repeated destination, and writeback never waits for older readers. A lookup made in the same cycle as a matching broadcast receives the broadcast value directly.

Top module: `rat_top`

## Requirements
- R1: After reset every entry is zero and every register-file word is zero, so every lookup returns tag 0 and value 0.
- R2: A dispatch with a destination (`disp_valid`=1, `disp_wr_dst`=1) sets the destination's entry to `disp_tag` from the next cycle on. This holds even when the entry already names another station, and dispatch is never refused.
- R3: A lookup is combinational and uses the state from before this cycle's dispatch. An entry of zero returns tag 0 and the register-file word. A nonzero entry returns that tag with value 0.
- R4: A broadcast (`wb_valid`=1, nonzero `wb_tag`) whose tag equals a register's entry writes `wb_value` into that register's file word and clears the entry, both visible from the next cycle.
- R5: A broadcast whose tag no register's entry names leaves all entries and all register-file words unchanged.
- R6: A dispatch with `disp_wr_dst`=0, a cycle with `wb_valid`=0, or a broadcast of tag 0 changes no entry and no register-file word.
- R7: When a dispatch renames a register in the same cycle that a matching broadcast clears it, the entry takes the new dispatch tag, and the register-file word still takes the broadcast value.
- R8: A lookup whose entry equals the tag broadcast in the same cycle returns tag 0 and `wb_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A dispatch takes place this cycle |
| disp_wr_dst | input | 1 | The dispatched operation writes a destination register |
| disp_dst | input | REG_W (3) | Destination register index |
| disp_tag | input | TAG_W (3) | Station allocated to the dispatched operation, nonzero |
| src_idx | input | NUM_SRC*REG_W (6) | Source register indices, source s in bits [s*REG_W +: REG_W] |
| src_tag | output | NUM_SRC*TAG_W (6) | Pending tag per source, 0 when the value is ready |
| src_val | output | NUM_SRC*DATA_W (32) | Ready value per source, 0 when pending |
| wb_valid | input | 1 | Result broadcast this cycle |
| wb_tag | input | TAG_W (3) | Station broadcasting its result |
| wb_value | input | DATA_W (16) | Broadcast result value |

## Verification
The assertions assume that station tags are unique while in flight. A dispatch never allocates a tag that has been dispatched and not yet broadcast, and only in-flight tags are broadcast, so at most one entry can ever match. The stimulus follows this rule by keeping a busy set of tags. Dispatch draws only from tags that were free before the cycle, and broadcasts draw only from the busy set. Dispatches without a destination and cycles with the broadcast disabled carry arbitrary tag and value fields, so the assertions may not assume anything about those fields.

// File: rtl/rat_pkg.sv
package rat_pkg;
  // where a lookup takes its answer from
  typedef enum logic [1:0] {
    LK_FILE = 2'd0,  // entry is zero, value from register file
    LK_BUS  = 2'd1,  // entry matches this cycle's broadcast
    LK_WAIT = 2'd2   // entry names a producer still running
  } lk_kind_t;
endpackage

// File: rtl/rat_map.sv
module rat_map #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int REG_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_we,
  input  logic [REG_W-1:0]          ren_dst,
  input  logic [TAG_W-1:0]          ren_tag,
  input  logic                      wb_valid,
  input  logic [TAG_W-1:0]          wb_tag,
  output logic [NUM_REGS*TAG_W-1:0] map_flat,
  output logic [NUM_REGS-1:0]       wb_hit
);
  function automatic logic tag_hit(input logic v, input logic [TAG_W-1:0] ent,
                                   input logic [TAG_W-1:0] t);
    return v && (t != '0) && (ent == t);
  endfunction

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    logic [TAG_W-1:0] ent_q;
    logic             ren_here;
    assign ren_here = ren_we && (ren_dst == REG_W'(r));
    assign wb_hit[r] = tag_hit(wb_valid, ent_q, wb_tag);
    assign map_flat[r*TAG_W +: TAG_W] = ent_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ent_q <= '0;
      else if (ren_here) ent_q <= ren_tag;   // younger rename wins
      else if (wb_hit[r]) ent_q <= '0;
    end
  end
endmodule

// File: rtl/rat_regfile.sv
module rat_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_REGS-1:0]        we,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] arf_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    logic [DATA_W-1:0] word_q;
    assign arf_flat[r*DATA_W +: DATA_W] = word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (we[r]) word_q <= wdata;
    end
  end
endmodule

// File: rtl/rat_lookup.sv
module rat_lookup
  import rat_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int REG_W    = 3,
  parameter int DATA_W   = 16
) (
  input  logic [REG_W-1:0]           idx,
  input  logic [NUM_REGS*TAG_W-1:0]  map_flat,
  input  logic [NUM_REGS*DATA_W-1:0] arf_flat,
  input  logic                       wb_valid,
  input  logic [TAG_W-1:0]           wb_tag,
  input  logic [DATA_W-1:0]          wb_value,
  output logic [TAG_W-1:0]           tag,
  output logic [DATA_W-1:0]          val,
  output lk_kind_t                   kind
);
  function automatic lk_kind_t classify(input logic [TAG_W-1:0] ent, input logic v,
                                        input logic [TAG_W-1:0] t);
    if (ent == '0)           return LK_FILE;
    else if (v && ent == t)  return LK_BUS;
    else                     return LK_WAIT;
  endfunction

  logic [TAG_W-1:0]  ent;
  logic [DATA_W-1:0] word;
  assign ent  = map_flat[idx*TAG_W +: TAG_W];
  assign word = arf_flat[idx*DATA_W +: DATA_W];
  assign kind = classify(ent, wb_valid, wb_tag);

  always_comb begin
    unique case (kind)
      LK_FILE: begin tag = '0;  val = word;     end
      LK_BUS:  begin tag = '0;  val = wb_value; end
      default: begin tag = ent; val = '0;       end
    endcase
  end
endmodule

// File: rtl/rat_top.sv
module rat_top #(
  parameter int NUM_REGS     = 8,
  parameter int NUM_STATIONS = 7,
  parameter int DATA_W       = 16,
  parameter int NUM_SRC      = 2,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(NUM_STATIONS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      disp_valid,
  input  logic                      disp_wr_dst,
  input  logic [REG_W-1:0]          disp_dst,
  input  logic [TAG_W-1:0]          disp_tag,
  input  logic [NUM_SRC*REG_W-1:0]  src_idx,
  output logic [NUM_SRC*TAG_W-1:0]  src_tag,
  output logic [NUM_SRC*DATA_W-1:0] src_val,
  input  logic                      wb_valid,
  input  logic [TAG_W-1:0]          wb_tag,
  input  logic [DATA_W-1:0]         wb_value
);
  import rat_pkg::*;

  logic                       ren_we;
  logic [NUM_REGS*TAG_W-1:0]  map_flat;
  logic [NUM_REGS*DATA_W-1:0] arf_flat;
  logic [NUM_REGS-1:0]        wb_hit;
  lk_kind_t                   lk_kind [NUM_SRC];

  assign ren_we = disp_valid && disp_wr_dst;

  rat_map #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .REG_W(REG_W)) u_map (
    .clk(clk), .rst_n(rst_n), .ren_we(ren_we), .ren_dst(disp_dst),
    .ren_tag(disp_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .map_flat(map_flat), .wb_hit(wb_hit));

  rat_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_arf (
    .clk(clk), .rst_n(rst_n), .we(wb_hit), .wdata(wb_value),
    .arf_flat(arf_flat));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rat_lookup #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .REG_W(REG_W),
                 .DATA_W(DATA_W)) u_lk (
      .idx(src_idx[s*REG_W +: REG_W]), .map_flat(map_flat),
      .arf_flat(arf_flat), .wb_valid(wb_valid), .wb_tag(wb_tag),
      .wb_value(wb_value), .tag(src_tag[s*TAG_W +: TAG_W]),
      .val(src_val[s*DATA_W +: DATA_W]), .kind(lk_kind[s]));
  end
endmodule

// File: rtl/rat_top_chk.sv
module rat_top_chk #(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 3,
  parameter int REG_W    = 3,
  parameter int DATA_W   = 16,
  parameter int NUM_SRC  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       disp_valid,
  input logic                       disp_wr_dst,
  input logic [REG_W-1:0]           disp_dst,
  input logic [TAG_W-1:0]           disp_tag,
  input logic [NUM_SRC*REG_W-1:0]   src_idx,
  input logic [NUM_SRC*TAG_W-1:0]   src_tag,
  input logic [NUM_SRC*DATA_W-1:0]  src_val,
  input logic                       wb_valid,
  input logic [TAG_W-1:0]           wb_tag,
  input logic [DATA_W-1:0]          wb_value,
  input logic [NUM_REGS*TAG_W-1:0]  map_flat,
  input logic [NUM_REGS*DATA_W-1:0] arf_flat,
  input logic [NUM_REGS-1:0]        wb_hit
);
  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_hit));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    // R2
    rename_sets_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_wr_dst && disp_dst == REG_W'(r))
      |=> map_flat[r*TAG_W +: TAG_W] == $past(disp_tag));
    // R4
    match_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_hit[r] && !(disp_valid && disp_wr_dst && disp_dst == REG_W'(r)))
      |=> map_flat[r*TAG_W +: TAG_W] == '0);
    // R7
    match_writes_file_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_hit[r] |=> arf_flat[r*DATA_W +: DATA_W] == $past(wb_value));
    // R5
    no_match_file_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_hit[r] |=> $stable(arf_flat[r*DATA_W +: DATA_W]));
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    // R8
    same_cycle_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_tag != '0 &&
       map_flat[src_idx[s*REG_W +: REG_W]*TAG_W +: TAG_W] == wb_tag)
      |-> (src_tag[s*TAG_W +: TAG_W] == '0 &&
           src_val[s*DATA_W +: DATA_W] == wb_value));
    // R3
    pending_value_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_tag[s*TAG_W +: TAG_W] != '0 |-> src_val[s*DATA_W +: DATA_W] == '0);
  end
endmodule

bind rat_top rat_top_chk #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .REG_W(REG_W),
                           .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_wr_dst(disp_wr_dst),
  .disp_dst(disp_dst), .disp_tag(disp_tag), .src_idx(src_idx),
  .src_tag(src_tag), .src_val(src_val), .wb_valid(wb_valid), .wb_tag(wb_tag),
  .wb_value(wb_value), .map_flat(map_flat), .arf_flat(arf_flat),
  .wb_hit(wb_hit));

// File: tb/rat_top_test.sv
module rat_top_test;
  localparam int NR = 8;
  localparam int NT = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0, disp_wr_dst = 1'b0;
  logic [2:0]  disp_dst = '0, disp_tag = '0;
  logic [5:0]  src_idx = '0;
  logic [5:0]  src_tag;
  logic [31:0] src_val;
  logic        wb_valid = 1'b0;
  logic [2:0]  wb_tag = '0;
  logic [15:0] wb_value = '0;

  int total = 0, bad = 0;
  bit finished = 0;
  int map_m [NR];
  int arf_m [NR];
  bit busy [NT+1];

  rat_top uut (.clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
    .disp_wr_dst(disp_wr_dst), .disp_dst(disp_dst), .disp_tag(disp_tag),
    .src_idx(src_idx), .src_tag(src_tag), .src_val(src_val),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value));

  always #2 clk = ~clk;

  // drive on falling edge, compare 1 ns later, then advance the model
  task automatic step(input bit dv, input bit dh, input int dd, input int dt,
                      input int s0, input int s1, input bit wv, input int wt,
                      input int wval, input string req);
    int sidx [2];
    sidx[0] = s0; sidx[1] = s1;
    @(negedge clk);
    disp_valid = dv; disp_wr_dst = dh; disp_dst = 3'(dd); disp_tag = 3'(dt);
    src_idx = {3'(s1), 3'(s0)};
    wb_valid = wv; wb_tag = 3'(wt); wb_value = 16'(wval);
    #1;
    for (int s = 0; s < 2; s++) begin
      int et, ev, m;
      m = map_m[sidx[s]];
      if (m == 0) begin et = 0; ev = arf_m[sidx[s]]; end
      else if (wv && wt == m) begin et = 0; ev = wval & 16'hFFFF; end
      else begin et = m; ev = 0; end
      total++;
      if (int'(src_tag[s*3 +: 3]) != et || int'(src_val[s*16 +: 16]) != ev) begin
        bad++;
        $display("FAIL %s src%0d reg%0d: tag=%0d val=%h expected tag=%0d val=%h",
                 req, s, sidx[s], src_tag[s*3 +: 3], src_val[s*16 +: 16], et, ev);
      end
    end
    if (wv && wt != 0) begin
      for (int r = 0; r < NR; r++)
        if (map_m[r] == wt) begin map_m[r] = 0; arf_m[r] = wval & 16'hFFFF; end
      busy[wt] = 0;
    end
    if (dv && dh) begin map_m[dd] = dt; busy[dt] = 1; end
  endtask

  initial begin
    for (int r = 0; r < NR; r++) begin map_m[r] = 0; arf_m[r] = 0; end
    for (int t = 0; t <= NT; t++) busy[t] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state on several registers
    step(0,0,0,0, 0,7, 0,0,0, "R1");
    step(0,0,0,0, 3,5, 0,0,0, "R1");
    // R2: rename r2 to station 3, then overwrite with 5 (no WAW stall)
    step(1,1,2,3, 2,2, 0,0,0, "R3");
    step(1,1,2,5, 2,1, 0,0,0, "R2");
    step(0,0,0,0, 2,1, 0,0,0, "R2");
    // R5: stale station 3 broadcasts, r2 stays on station 5
    step(0,0,0,0, 2,0, 1,3,16'hAAAA, "R5");
    step(0,0,0,0, 2,0, 0,0,0, "R5");
    // R8: station 5 broadcasts, looked up in the same cycle
    step(0,0,0,0, 2,2, 1,5,16'h1234, "R8");
    // R4: r2 now from file holds station 5's value, not the stale one
    step(0,0,0,0, 2,3, 0,0,0, "R4");
    // R6: store-like dispatch and disabled/zero broadcast change nothing
    step(1,0,4,6, 4,2, 0,5,16'h7777, "R6");
    step(0,0,0,0, 4,2, 1,0,16'h5555, "R6");
    step(0,0,0,0, 4,2, 0,0,0, "R6");
    // R7: rename r1 while its old producer broadcasts
    step(1,1,1,2, 1,1, 0,0,0, "R3");
    step(1,1,1,4, 1,1, 1,2,16'h0BEE, "R7");
    step(0,0,0,0, 1,1, 0,0,0, "R7");
    step(0,0,0,0, 1,6, 1,4,16'h0C0D, "R8");
    step(0,0,0,0, 1,6, 0,0,0, "R4");

    // random traffic against the model, unique in-flight tags
    for (int n = 0; n < 4000; n++) begin
      bit dv, dh, wv;
      int dt, wt, off;
      dv = ($urandom % 3) != 0;
      dh = ($urandom % 5) != 0;
      dt = 0;
      off = $urandom % NT;
      for (int k = 0; k < NT; k++) begin
        int t;
        t = ((off + k) % NT) + 1;
        if (dt == 0 && !busy[t]) dt = t;
      end
      if (dv && dh && dt == 0) dv = 0;
      if (dt == 0) dt = 1 + ($urandom % NT);
      wv = ($urandom % 2) != 0;
      wt = 0;
      off = $urandom % NT;
      for (int k = 0; k < NT; k++) begin
        int t;
        t = ((off + k) % NT) + 1;
        if (wt == 0 && busy[t]) wt = t;
      end
      if (wt == 0) wv = 0;
      if (!wv) wt = $urandom % (NT + 1);
      step(dv, dh, $urandom % NR, dt, $urandom % NR, $urandom % NR,
           wv, wt, $urandom & 16'hFFFF, "R3");
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule